// File: doc/BRIEF.md
# Near-Base Deviation Multiplier

This block multiplies two unsigned operands and registers the full-width product. For each operand it finds the power of two closest in value, 2^K, and the signed distance Z from it, so that the operand equals 2^K + Z. When both operands sit close to their bases, it forms the product from two shifts and one narrow signed product of the two distances: X·Y = (X << K2) + (Z2 << K1) + Z1·Z2. Any other operand pair goes to a general shift-and-add multiplier.

Exactly one of the two arithmetic paths receives live operands for a given operation. The other path sees all-zero operands and stays quiet. A strobe marks a valid operand pair. One clock later the product appears together with a one-cycle valid pulse and a flag that says which path made it. Between strobes the product and the flag keep their last values.

Top module: `nb_mult`

## Requirements
- R1: On a clock edge where `in_valid` is 1, `prod_out` is loaded with the full 16-bit unsigned product `a_in * b_in` and becomes visible after that edge.
- R2: `prod_valid` is 1 in exactly the cycle after each edge that samples `in_valid` = 1, and 0 after every edge that samples `in_valid` = 0.
- R3: For a non-zero operand X with most significant set bit m, the base is 2^m when X − 2^m ≤ 2^(m+1) − X, and 2^(m+1) otherwise (ties take the lower base). For example 60 has base 64 and deviation −4, which makes it near.
- R4: An operand is near when 5·|Z| ≤ 2^K. `near_used` is 1 exactly when both operands are non-zero and near, for example 76 (Z = 12) is near and 77 (Z = 13) is not.
- R5: If either operand is zero, `prod_out` becomes 0 and `near_used` becomes 0.
- R6: On an edge with `in_valid` = 0, `prod_out` and `near_used` keep their previous values.
- R7: Only the selected path is given operands. The path not chosen receives zeros, and consecutive operations that switch paths each produce the correct product.
- R8: While `rst_n` is 0 at a clock edge, `prod_out`, `prod_valid` and `near_used` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair strobe |
| a_in | input | 8 | First unsigned operand |
| b_in | input | 8 | Second unsigned operand |
| prod_out | output | 16 | Registered product |
| prod_valid | output | 1 | One-cycle pulse after a strobe |
| near_used | output | 1 | 1 if the near-base path made the registered product |

## Verification
The assertions assume that `a_in` and `b_in` are stable and known at every edge where `in_valid` is high. They also assume that the reset is held across at least one edge before the first strobe. The bench drives all inputs at the falling edge, clears them to zero during reset, and never leaves an operand undriven. An exhaustive back-to-back sweep of all 65,536 operand pairs keeps the strobe high without a gap and so exercises path switches on every cycle. The directed cases cover the 5·|Z| boundary at base 64 and the zero bypass.

// File: rtl/nb_pkg.sv
// Shared types for the near-base multiplier.
// Assumes nothing beyond a single clock domain.
package nb_pkg;
    typedef enum logic {
        PATH_GENERAL = 1'b0,
        PATH_NEAR    = 1'b1
    } path_e;
endpackage

// File: rtl/nb_base_sel.sv
// Base selection and exponent stage for one operand.
// Finds the power of two nearest to x (ties to the lower one), the signed
// deviation from it, and whether the deviation passes the 5*|Z| <= 2^K test.
// Assumes x is unsigned; a zero operand reports nz = 0 and near = 0.
module nb_base_sel #(
    parameter int W  = 8,
    parameter int KW = $clog2(W + 1),
    parameter int ZW = W + 1
) (
    input  logic [W-1:0]        x,
    output logic [KW-1:0]       k,
    output logic signed [ZW-1:0] z,
    output logic                near,
    output logic                nz
);
    localparam int EW = W + 1;
    localparam int MW = W + 4;

    logic [KW-1:0] msb;
    logic [EW-1:0] xe, lo_b, hi_b, d_lo, d_hi, mag, base;
    logic [MW-1:0] five_mag;

    // Locate the most significant set bit of the operand.
    always_comb begin
        msb = '0;
        for (int i = 0; i < W; i++) begin
            if (x[i]) msb = KW'(i);
        end
    end

    // Compare distances to both bracketing powers of two and pick one.
    always_comb begin
        xe   = {1'b0, x};
        lo_b = EW'(1) << msb;
        hi_b = lo_b << 1;
        d_lo = xe - lo_b;
        d_hi = hi_b - xe;
        if (d_lo <= d_hi) begin
            k    = msb;
            z    = $signed(d_lo);
            mag  = d_lo;
            base = lo_b;
        end else begin
            k    = msb + KW'(1);
            z    = -$signed(d_hi);
            mag  = d_hi;
            base = hi_b;
        end
    end

    // Nearness test without division.
    always_comb begin
        nz       = |x;
        five_mag = MW'(mag) * MW'(5);
        near     = nz && (five_mag <= MW'(base));
    end
endmodule

// File: rtl/nb_near_path.sv
// Near-base product unit: X*Y = (X << K2) + (Z2 << K1) + Z1*Z2.
// Assumes operands are already isolated to zero when this path is idle,
// in which case every term and the result are zero.
module nb_near_path #(
    parameter int W  = 8,
    parameter int KW = $clog2(W + 1),
    parameter int ZW = W + 1,
    parameter int PW = 2 * W
) (
    input  logic [W-1:0]         x,
    input  logic [KW-1:0]        k1,
    input  logic [KW-1:0]        k2,
    input  logic signed [ZW-1:0] z1,
    input  logic signed [ZW-1:0] z2,
    output logic [PW-1:0]        p
);
    localparam int SW = PW + 2;

    logic signed [SW-1:0]     t_shift_x, t_shift_z, t_dev, sum;
    logic signed [2*ZW-1:0]   dev_prod;

    // Form the three terms and add them in signed arithmetic.
    always_comb begin
        dev_prod  = z1 * z2;
        t_shift_x = $signed({{(SW - W){1'b0}}, x}) <<< k2;
        t_shift_z = $signed({{(SW - ZW){z2[ZW-1]}}, z2}) <<< k1;
        t_dev     = $signed({{(SW - 2 * ZW){dev_prod[2*ZW-1]}}, dev_prod});
        sum       = t_shift_x + t_shift_z + t_dev;
        p         = sum[PW-1:0];
    end
endmodule

// File: rtl/nb_gen_path.sv
// General unsigned multiplier built as a chain of shifted partial products.
// Assumes operands are forced to zero when this path is idle.
module nb_gen_path #(
    parameter int W  = 8,
    parameter int PW = 2 * W
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [PW-1:0] p
);
    logic [PW-1:0] acc [W+1];

    assign acc[0] = '0;

    // One partial product row per multiplier bit, accumulated in sequence.
    for (genvar i = 0; i < W; i++) begin : g_row
        logic [PW-1:0] row;
        assign row        = b[i] ? (PW'(a) << i) : '0;
        assign acc[i + 1] = acc[i] + row;
    end

    assign p = acc[W];
endmodule

// File: rtl/nb_mult.sv
// Top level: hybrid near-base / general multiplier with one result register.
// Chooses the near-base path when both operands are non-zero and near,
// the general path otherwise; the unselected path receives zero operands.
// Assumes operands are stable around every edge where in_valid is high.
module nb_mult #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [2*W-1:0] prod_out,
    output logic         prod_valid,
    output logic         near_used
);
    import nb_pkg::*;

    localparam int KW = $clog2(W + 1);
    localparam int ZW = W + 1;
    localparam int PW = 2 * W;
    localparam int NOP = 2;

    logic [W-1:0]         opnd   [NOP];
    logic [KW-1:0]        k_sel  [NOP];
    logic signed [ZW-1:0] z_sel  [NOP];
    logic [NOP-1:0]       is_near, is_nz;

    assign opnd[0] = a_in;
    assign opnd[1] = b_in;

    // One base selection / exponent unit per operand.
    for (genvar i = 0; i < NOP; i++) begin : g_base
        nb_base_sel #(.W(W), .KW(KW), .ZW(ZW)) u_sel (
            .x    (opnd[i]),
            .k    (k_sel[i]),
            .z    (z_sel[i]),
            .near (is_near[i]),
            .nz   (is_nz[i])
        );
    end

    path_e                path_sel;
    logic                 run_near, run_gen;
    logic [W-1:0]         nx_g, ga_g, gb_g;
    logic [KW-1:0]        nk1_g, nk2_g;
    logic signed [ZW-1:0] nz1_g, nz2_g;
    logic [PW-1:0]        p_near, p_gen, p_mux;

    // Steer the operation and isolate the idle path's operands.
    always_comb begin
        path_sel = (&is_near) ? PATH_NEAR : PATH_GENERAL;
        run_near = in_valid && (path_sel == PATH_NEAR);
        run_gen  = in_valid && (path_sel == PATH_GENERAL) && (&is_nz);
        nx_g     = run_near ? a_in     : '0;
        nk1_g    = run_near ? k_sel[0] : '0;
        nk2_g    = run_near ? k_sel[1] : '0;
        nz1_g    = run_near ? z_sel[0] : '0;
        nz2_g    = run_near ? z_sel[1] : '0;
        ga_g     = run_gen  ? a_in     : '0;
        gb_g     = run_gen  ? b_in     : '0;
    end

    nb_near_path #(.W(W), .KW(KW), .ZW(ZW), .PW(PW)) u_near (
        .x  (nx_g),
        .k1 (nk1_g),
        .k2 (nk2_g),
        .z1 (nz1_g),
        .z2 (nz2_g),
        .p  (p_near)
    );

    nb_gen_path #(.W(W), .PW(PW)) u_gen (
        .a (ga_g),
        .b (gb_g),
        .p (p_gen)
    );

    // Pick the active path's result; both are zero for a zero operand.
    always_comb begin
        p_mux = run_near ? p_near : p_gen;
    end

    // Result register with valid pulse and path flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_out   <= '0;
            prod_valid <= 1'b0;
            near_used  <= 1'b0;
        end else begin
            prod_valid <= in_valid;
            if (in_valid) begin
                prod_out  <= p_mux;
                near_used <= run_near;
            end
        end
    end
endmodule

// File: rtl/nb_mult_chk.sv
// Assertion checker for nb_mult, attached with bind.
// Assumes operands are known at every edge with in_valid high.
module nb_mult_chk #(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [W-1:0]   a_in,
    input logic [W-1:0]   b_in,
    input logic [2*W-1:0] prod_out,
    input logic           prod_valid,
    input logic           near_used,
    input logic           run_near,
    input logic [W-1:0]   nx_g,
    input logic [W-1:0]   ga_g,
    input logic [W-1:0]   gb_g
);
    AST_PRODUCT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> prod_out == ((2*W)'($past(a_in)) * (2*W)'($past(b_in)))); // R1

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> prod_valid); // R2

    AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !prod_valid); // R2

    AST_ZERO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (a_in == '0 || b_in == '0)) |=> (prod_out == '0 && !near_used)); // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(prod_out) && $stable(near_used))); // R6

    AST_NEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_near |-> nx_g == '0); // R7

    AST_GEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        run_near |-> (ga_g == '0 && gb_g == '0)); // R7

    AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> near_used == $past(run_near)); // R4
endmodule

bind nb_mult nb_mult_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .a_in       (a_in),
    .b_in       (b_in),
    .prod_out   (prod_out),
    .prod_valid (prod_valid),
    .near_used  (near_used),
    .run_near   (run_near),
    .nx_g       (nx_g),
    .ga_g       (ga_g),
    .gb_g       (gb_g)
);

// File: tb/tb_nb_mult.sv
module tb_nb_mult;
    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [W-1:0]   a_in = '0;
    logic [W-1:0]   b_in = '0;
    logic [2*W-1:0] prod_out;
    logic           prod_valid;
    logic           near_used;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    nb_mult #(.W(W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .a_in       (a_in),
        .b_in       (b_in),
        .prod_out   (prod_out),
        .prod_valid (prod_valid),
        .near_used  (near_used)
    );

    // Watchdog: a hung run is one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Reference nearness from the requirements (R3, R4).
    function automatic bit ref_near(int x);
        int m, lo, dl, dh, mag, base;
        if (x == 0) return 1'b0;
        m = 0;
        for (int i = 0; i < W; i++) if (x[i]) m = i;
        lo = 1 << m;
        dl = x - lo;
        dh = 2 * lo - x;
        if (dl <= dh) begin mag = dl; base = lo; end
        else begin mag = dh; base = 2 * lo; end
        return (5 * mag <= base);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Apply one strobe and check product, valid and path one edge later.
    task automatic run_one(input int a, input int b, input int exp_p, input int exp_n, input string req);
        @(negedge clk);
        a_in = W'(a); b_in = W'(b); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(prod_out == 16'(exp_p), {req, " product"}, prod_out, exp_p);
        check(near_used == 1'(exp_n), {req, " path"}, near_used, exp_n);
        check(prod_valid == 1'b1, {req, " valid"}, prod_valid, 1);
    endtask

    task automatic t_reset();
        check(prod_out == '0, "R8 product at reset", prod_out, 0);
        check(prod_valid == 1'b0, "R8 valid at reset", prod_valid, 0);
        check(near_used == 1'b0, "R8 path at reset", near_used, 0);
    endtask

    task automatic t_near_cases();
        run_one(60, 70, 4200, 1, "R3 upper base for 60");
        run_one(128, 128, 16384, 1, "R1 exact powers");
        run_one(255, 255, 65025, 1, "R1 top of range");
        run_one(1, 1, 1, 1, "R4 unit operands");
    endtask

    task automatic t_fallback();
        run_one(96, 96, 9216, 0, "R4 tie far from base");
        run_one(100, 128, 12800, 0, "R4 one operand far");
        run_one(3, 3, 9, 0, "R3 tie small operand");
    endtask

    task automatic t_threshold();
        run_one(76, 255, 19380, 1, "R4 5|Z| just inside");
        run_one(77, 255, 19635, 0, "R4 5|Z| just outside");
    endtask

    task automatic t_zero();
        run_one(0, 200, 0, 0, "R5 zero first");
        run_one(128, 0, 0, 0, "R5 zero second");
    endtask

    task automatic t_valid_hold();
        run_one(64, 64, 4096, 1, "R2 strobe");
        @(negedge clk);
        a_in = 8'd7; b_in = 8'd9;
        check(prod_valid == 1'b0, "R2 valid drops", prod_valid, 0);
        @(negedge clk);
        check(prod_out == 16'd4096, "R6 product held", prod_out, 4096);
        check(near_used == 1'b1, "R6 path held", near_used, 1);
    endtask

    task automatic t_alternate();
        @(negedge clk);
        a_in = 8'd128; b_in = 8'd130; in_valid = 1'b1;
        @(negedge clk);
        check(prod_out == 16'd16640 && near_used, "R7 near then", prod_out, 16640);
        a_in = 8'd96; b_in = 8'd200;
        @(negedge clk);
        check(prod_out == 16'd19200 && !near_used, "R7 general then", prod_out, 19200);
        a_in = 8'd31; b_in = 8'd33;
        @(negedge clk);
        in_valid = 1'b0;
        check(prod_out == 16'd1023 && near_used, "R7 near again", prod_out, 1023);
    endtask

    // Exhaustive back-to-back sweep against the reference (R1, R4).
    task automatic t_sweep();
        int pa = 0, pb = 0;
        bit have = 1'b0;
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                @(negedge clk);
                if (have) begin
                    int ep = pa * pb;
                    int en = ref_near(pa) && ref_near(pb);
                    checks++;
                    if (prod_out != 16'(ep) || near_used != 1'(en) || !prod_valid) begin
                        errors++;
                        $display("FAIL R1/R4 sweep %0d*%0d: actual %0d/%0d expected %0d/%0d",
                                 pa, pb, prod_out, near_used, ep, en);
                    end
                end
                a_in = W'(a); b_in = W'(b); in_valid = 1'b1;
                pa = a; pb = b; have = 1'b1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        check(prod_out == 16'(pa * pb), "R1 sweep last", prod_out, pa * pb);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_near_cases();
        t_fallback();
        t_threshold();
        t_zero();
        t_valid_hold();
        t_alternate();
        t_sweep();
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule